// File: doc/BRIEF.md
# Presence-Tracking Snoop Filter

This block sits between a shared coherence bus and a group of caches on the receiving side. It keeps a small set-associative directory of recently moved blocks. Each entry holds a block tag and one bit per cache. From every coherent transaction on the bus it works out which caches need to look up their tags. It then returns that answer as a per-cache enable mask, so a cache whose bit is clear skips the lookup. The bus broadcast still reaches every cache; only the tag lookups at the receivers are removed.

The filter has two hit meanings, selected by a mode input that is held while reset is asserted. In presence mode an entry lists the caches that may hold the block. A block with no entry is held by nobody. When a valid entry is pushed out to make room, the filter asks every cache listed in it to drop the block, so the directory always covers everything the caches hold. In absence mode an entry records a block that no cache holds. A hit therefore lets every cache skip its lookup, and a miss has to fall back to asking all caches except the requester.

Transactions arrive one per cycle at most. Each carries a block address, a kind and the index of the requesting cache. The low address bits select the set and the upper bits form the tag. Kind encoding: 0 read fill, 1 write (ownership), 2 eviction notice, 3 invalidate.

Top module: `snoop_filter`

## Requirements
- R1: While rst_ni is low, and after it rises, all outputs are zero and every directory entry is empty, so the first access to any block after reset misses.
- R2: snp_vld_o is high in the cycle after each cycle with txn_vld_i high and low otherwise; without a transaction snp_mask_o is all zero.
- R3: Presence mode, read fill (kind 0) that hits: the mask is the entry's holders minus the requester, and the requester is added to the holders.
- R4: Presence mode, write (kind 1) that hits: the mask is the entry's holders minus the requester, and afterwards the requester is the sole holder.
- R5: Presence mode, read fill or write that misses: the mask is all zero and an entry is allocated with only the requester as holder.
- R6: An eviction notice (kind 2) never enables any snoop. In presence mode it removes the requester from a hitting entry and frees the entry once no holder remains. In absence mode it changes nothing.
- R7: Presence mode, invalidate (kind 3): on a hit the mask is the holders minus the requester and the entry is freed; on a miss the mask is zero and nothing is allocated.
- R8: An allocation uses the lowest-numbered free way of the set. If no way is free it uses the set's round-robin pointer, which starts at way 0 after reset and advances by one, modulo the way count, after each replacement.
- R9: In presence mode, replacing a valid entry raises binv_vld_o for one cycle, in the cycle after the transaction, with that entry's block address (tag above set index) and holder vector.
- R10: Absence mode hit: the mask is all zero. A read fill or write that hits frees the entry, and an invalidate that hits keeps it.
- R11: Absence mode miss of a read fill, write or invalidate: the mask has every cache except the requester. A missing invalidate allocates an absence entry. No back-invalidate is raised in absence mode.
- R12: The mode input is sampled as held throughout operation and changes only while rst_ni is low; each reset starts the chosen mode with an empty directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| excl_mode_i | input | 1 | 0 presence meaning, 1 absence meaning; change only in reset |
| txn_vld_i | input | 1 | A bus transaction is present this cycle |
| txn_addr_i | input | ADDR_W | Block address; low bits set index, high bits tag |
| txn_type_i | input | 2 | Kind: 0 read fill, 1 write, 2 eviction notice, 3 invalidate |
| txn_src_i | input | $clog2(N_CACHE) | Index of the requesting cache |
| snp_vld_o | output | 1 | Snoop mask is valid for the previous cycle's transaction |
| snp_mask_o | output | N_CACHE | Per-cache tag-lookup enable |
| binv_vld_o | output | 1 | Back-invalidate request valid |
| binv_addr_o | output | ADDR_W | Block address of the replaced entry |
| binv_mask_o | output | N_CACHE | Caches that must drop the replaced block |

## Verification
All results are registered. A transaction applied before rising edge k produces its snoop mask and any back-invalidate in the cycle after edge k. The directory update happens at that same edge, so a transaction at edge k+1 already sees it. The bench drives inputs on falling edges and advances a behavioural model of the directory by one transaction per cycle. At the next falling edge it compares the expected outputs with the ports. This alignment covers back-to-back transactions to the same block, including a fill followed at once by a hit.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    TXN_READ  = 2'd0,
    TXN_WRITE = 2'd1,
    TXN_EVICT = 2'd2,
    TXN_INVAL = 2'd3
  } txn_e;
endpackage

// File: rtl/sf_lookup.sv
module sf_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 10,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_vld_i,
  input  logic [TAG_W-1:0] way_tag_i [WAYS],
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic             free_o,
  output logic [WAY_W-1:0] free_way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_vld_i[w] && (way_tag_i[w] == tag_i);
  end

  // lowest index wins
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(i);
      end
      if (!way_vld_i[i]) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/sf_victim.sv
module sf_victim #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] set_i,
  output logic [WAY_W-1:0] ptr_o
);
  logic [WAY_W-1:0] rr_q [SETS];

  assign ptr_o = rr_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (adv_i) begin
      rr_q[set_i] <= (rr_q[set_i] == WAY_W'(WAYS - 1)) ? '0 : rr_q[set_i] + 1'b1;
    end
  end
endmodule

// File: rtl/sf_action.sv
module sf_action import sf_pkg::*; #(
  parameter int N_CACHE = 4,
  localparam int SRC_W = $clog2(N_CACHE)
) (
  input  logic               excl_i,
  input  txn_e               kind_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic               hit_i,
  input  logic [N_CACHE-1:0] hit_vec_i,
  output logic [N_CACHE-1:0] mask_o,
  output logic               keep_o,
  output logic [N_CACHE-1:0] new_vec_o,
  output logic               alloc_o
);
  logic [N_CACHE-1:0] req, others, left;

  assign req    = N_CACHE'(1) << src_i;
  assign others = ~req;
  assign left   = hit_vec_i & others;

  always_comb begin
    mask_o    = '0;
    keep_o    = hit_i;
    new_vec_o = hit_vec_i;
    alloc_o   = 1'b0;
    if (!excl_i) begin
      unique case (kind_i)
        TXN_READ, TXN_WRITE: begin
          if (hit_i) begin
            mask_o    = left;
            new_vec_o = (kind_i == TXN_READ) ? (hit_vec_i | req) : req;
          end else begin
            alloc_o   = 1'b1;
            new_vec_o = req;
          end
        end
        TXN_EVICT: begin
          new_vec_o = left;
          keep_o    = hit_i && (left != '0);
        end
        TXN_INVAL: begin
          mask_o = hit_i ? left : '0;
          keep_o = 1'b0;
        end
        default: ;
      endcase
    end else begin
      // entry = block held by no cache
      unique case (kind_i)
        TXN_READ, TXN_WRITE: begin
          mask_o = hit_i ? '0 : others;
          keep_o = 1'b0;
        end
        TXN_INVAL: begin
          mask_o    = hit_i ? '0 : others;
          alloc_o   = !hit_i;
          new_vec_o = '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter import sf_pkg::*; #(
  parameter int N_CACHE = 4,
  parameter int ADDR_W  = 12,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  localparam int SRC_W  = $clog2(N_CACHE),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               excl_mode_i,
  input  logic               txn_vld_i,
  input  logic [ADDR_W-1:0]  txn_addr_i,
  input  logic [1:0]         txn_type_i,
  input  logic [SRC_W-1:0]   txn_src_i,
  output logic               snp_vld_o,
  output logic [N_CACHE-1:0] snp_mask_o,
  output logic               binv_vld_o,
  output logic [ADDR_W-1:0]  binv_addr_o,
  output logic [N_CACHE-1:0] binv_mask_o
);
  logic               vld_q [SETS][WAYS];
  logic [TAG_W-1:0]   tag_q [SETS][WAYS];
  logic [N_CACHE-1:0] vec_q [SETS][WAYS];

  logic [IDX_W-1:0]   set_idx;
  logic [TAG_W-1:0]   tag;
  logic [WAYS-1:0]    set_vld;
  logic [TAG_W-1:0]   set_tag [WAYS];
  logic               hit, free_any, keep, alloc, rep;
  logic [WAY_W-1:0]   hit_way, free_way, rr_ptr, fill_way;
  logic [N_CACHE-1:0] hit_vec, mask, new_vec;

  assign set_idx = txn_addr_i[IDX_W-1:0];
  assign tag     = txn_addr_i[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_set
    assign set_vld[w] = vld_q[set_idx][w];
    assign set_tag[w] = tag_q[set_idx][w];
  end

  sf_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .way_vld_i (set_vld),
    .way_tag_i (set_tag),
    .tag_i     (tag),
    .hit_o     (hit),
    .hit_way_o (hit_way),
    .free_o    (free_any),
    .free_way_o(free_way)
  );

  assign hit_vec = vec_q[set_idx][hit_way];

  sf_action #(.N_CACHE(N_CACHE)) u_action (
    .excl_i   (excl_mode_i),
    .kind_i   (txn_e'(txn_type_i)),
    .src_i    (txn_src_i),
    .hit_i    (hit),
    .hit_vec_i(hit_vec),
    .mask_o   (mask),
    .keep_o   (keep),
    .new_vec_o(new_vec),
    .alloc_o  (alloc)
  );

  assign rep      = txn_vld_i && !hit && alloc && !free_any;
  assign fill_way = free_any ? free_way : rr_ptr;

  sf_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (rep),
    .set_i (set_idx),
    .ptr_o (rr_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
          vec_q[s][w] <= '0;
        end
      end
      snp_vld_o   <= 1'b0;
      snp_mask_o  <= '0;
      binv_vld_o  <= 1'b0;
      binv_addr_o <= '0;
      binv_mask_o <= '0;
    end else begin
      snp_vld_o  <= txn_vld_i;
      snp_mask_o <= txn_vld_i ? mask : '0;
      if (rep && !excl_mode_i) begin
        binv_vld_o  <= 1'b1;
        binv_addr_o <= {tag_q[set_idx][fill_way], set_idx};
        binv_mask_o <= vec_q[set_idx][fill_way];
      end else begin
        binv_vld_o  <= 1'b0;
        binv_addr_o <= '0;
        binv_mask_o <= '0;
      end
      if (txn_vld_i) begin
        if (hit) begin
          if (keep) vec_q[set_idx][hit_way] <= new_vec;
          else      vld_q[set_idx][hit_way] <= 1'b0;
        end else if (alloc) begin
          vld_q[set_idx][fill_way] <= 1'b1;
          tag_q[set_idx][fill_way] <= tag;
          vec_q[set_idx][fill_way] <= new_vec;
        end
      end
    end
  end
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int N_CACHE = 4,
  parameter int ADDR_W  = 12,
  localparam int SRC_W  = $clog2(N_CACHE)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               excl_mode_i,
  input logic               txn_vld_i,
  input logic [1:0]         txn_type_i,
  input logic [SRC_W-1:0]   txn_src_i,
  input logic               snp_vld_o,
  input logic [N_CACHE-1:0] snp_mask_o,
  input logic               binv_vld_o,
  input logic [N_CACHE-1:0] binv_mask_o
);
  logic [SRC_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= txn_src_i;
  end

  AST_SNP_TRACKS_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_vld_i |=> snp_vld_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_vld_i |=> (!snp_vld_o && snp_mask_o == '0)); // R2
  AST_NO_SELF_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_vld_o |-> !snp_mask_o[src_q]); // R4
  AST_EVICT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_vld_i && txn_type_i == 2'd2) |=> snp_mask_o == '0); // R6
  AST_BINV_HOLDERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    binv_vld_o |-> binv_mask_o != '0); // R9
  AST_EXCL_NO_BINV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excl_mode_i |-> !binv_vld_o); // R11
  AST_EXCL_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (excl_mode_i && snp_vld_o) |->
      (snp_mask_o == '0 || $countones(snp_mask_o) == N_CACHE - 1)); // R11
  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(excl_mode_i)); // R12
endmodule

bind snoop_filter sf_checker #(.N_CACHE(N_CACHE), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .excl_mode_i(excl_mode_i),
  .txn_vld_i  (txn_vld_i),
  .txn_type_i (txn_type_i),
  .txn_src_i  (txn_src_i),
  .snp_vld_o  (snp_vld_o),
  .snp_mask_o (snp_mask_o),
  .binv_vld_o (binv_vld_o),
  .binv_mask_o(binv_mask_o)
);

// File: tb/sim_snoop_filter.sv
`timescale 1ns/1ps
module sim_snoop_filter;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int NS = 4;
  localparam int NW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          excl = 1'b0;
  logic          t_vld = 1'b0;
  logic [AW-1:0] t_addr = '0;
  logic [1:0]    t_type = '0;
  logic [1:0]    t_src = '0;
  logic          snp_vld, binv_vld;
  logic [N-1:0]  snp_mask, binv_mask;
  logic [AW-1:0] binv_addr;

  always #10 clk = ~clk;

  snoop_filter #(.N_CACHE(N), .ADDR_W(AW), .SETS(NS), .WAYS(NW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .excl_mode_i(excl),
    .txn_vld_i(t_vld), .txn_addr_i(t_addr), .txn_type_i(t_type), .txn_src_i(t_src),
    .snp_vld_o(snp_vld), .snp_mask_o(snp_mask),
    .binv_vld_o(binv_vld), .binv_addr_o(binv_addr), .binv_mask_o(binv_mask)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural directory
  int mv [NS][NW], mt [NS][NW], mvec [NS][NW], mrr [NS];
  int e_vld, e_mask, e_bvld, e_baddr, e_bmask;
  string e_tag, force_tag = "";

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < NW; w++) begin mv[s][w] = 0; mt[s][w] = 0; mvec[s][w] = 0; end
    end
    e_vld = 0; e_mask = 0; e_bvld = 0; e_baddr = 0; e_bmask = 0; e_tag = "R1";
  endtask

  task automatic model_alloc(int s, int tg, int vec);
    int fw = -1;
    for (int w = NW - 1; w >= 0; w--) if (!mv[s][w]) fw = w;
    if (fw < 0) begin
      fw = mrr[s];
      mrr[s] = (mrr[s] + 1) % NW;
      if (!excl) begin
        e_bvld = 1; e_baddr = mt[s][fw] * NS + s; e_bmask = mvec[s][fw];
      end
    end
    mv[s][fw] = 1; mt[s][fw] = tg; mvec[s][fw] = vec;
  endtask

  task automatic model_step(bit v, int typ, int src, int addr);
    int s, tg, req, hw, all;
    e_vld = v; e_mask = 0; e_bvld = 0; e_baddr = 0; e_bmask = 0; e_tag = "R2";
    if (!v) return;
    s = addr % NS; tg = addr / NS; req = 1 << src; all = (1 << N) - 1; hw = -1;
    for (int w = NW - 1; w >= 0; w--) if (mv[s][w] && mt[s][w] == tg) hw = w;
    if (!excl) begin
      case (typ)
        0, 1: begin
          if (hw >= 0) begin
            e_mask = mvec[s][hw] & ~req & all;
            mvec[s][hw] = (typ == 0) ? (mvec[s][hw] | req) : req;
            e_tag = (typ == 0) ? "R3" : "R4";
          end else begin
            e_tag = "R5";
            model_alloc(s, tg, req);
          end
        end
        2: begin
          e_tag = "R6";
          if (hw >= 0) begin
            mvec[s][hw] = mvec[s][hw] & ~req & all;
            if (mvec[s][hw] == 0) mv[s][hw] = 0;
          end
        end
        default: begin
          e_tag = "R7";
          if (hw >= 0) begin e_mask = mvec[s][hw] & ~req & all; mv[s][hw] = 0; end
        end
      endcase
    end else begin
      if (typ == 2) e_tag = "R6";
      else if (hw >= 0) begin
        e_tag = "R10";
        if (typ != 3) mv[s][hw] = 0;
      end else begin
        e_tag = "R11";
        e_mask = all & ~req;
        if (typ == 3) model_alloc(s, tg, 0);
      end
    end
    if (force_tag != "") begin e_tag = force_tag; force_tag = ""; end
  endtask

  task automatic compare();
    chk(e_tag == "R1" ? "R1" : "R2", "snp_vld", snp_vld, e_vld);
    chk(e_tag, "snp_mask", snp_mask, e_mask);
    chk("R9", "binv_vld", binv_vld, e_bvld);
    if (e_bvld) begin
      chk("R8", "binv_addr", binv_addr, e_baddr);
      chk("R9", "binv_mask", binv_mask, e_bmask);
    end
  endtask

  task automatic cycle(bit v, int typ, int src, int addr);
    @(negedge clk);
    compare();
    model_step(v, typ, src, addr);
    t_vld = v; t_type = 2'(typ); t_src = 2'(src); t_addr = AW'(addr);
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst_ni = 1'b0; t_vld = 1'b0; excl = mode;
    model_clear();
    repeat (3) begin
      @(negedge clk);
      chk("R1", "snp_vld", snp_vld, 0);
      chk("R1", "snp_mask", snp_mask, 0);
      chk("R1", "binv_vld", binv_vld, 0);
    end
    rst_ni = 1'b1;
    e_tag = "R1";
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++)
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 5) * NS + $urandom_range(0, NS - 1));
  endtask

  initial begin
    do_reset(0);
    // presence mode, block 0x21 (set 1)
    cycle(1, 0, 0, 'h21);   // R5 miss
    cycle(1, 0, 1, 'h21);   // R3 mask 0001
    cycle(1, 1, 2, 'h21);   // R4 mask 0011
    cycle(1, 0, 0, 'h21);   // R3 mask 0100
    cycle(1, 2, 0, 'h21);   // R6
    cycle(1, 2, 2, 'h21);   // R6 entry freed
    cycle(1, 0, 1, 'h21);   // R5 miss again
    cycle(1, 3, 3, 'h21);   // R7 mask 0010
    cycle(1, 3, 3, 'h21);   // R7 miss
    // set 0 fill and replace
    cycle(1, 0, 0, 'h04);
    cycle(1, 0, 1, 'h08);
    cycle(1, 0, 2, 'h0C);   // R8 replaces way 0, R9 binv 0x04 mask 0001
    cycle(1, 0, 3, 'h10);   // R8 replaces way 1, binv 0x08 mask 0010
    cycle(1, 1, 1, 'h0C);   // hit R4 mask 0100
    cycle(0, 0, 0, 0);
    rand_run(4000);
    do_reset(0);
    force_tag = "R1";
    cycle(1, 0, 1, 'h0C);   // R1 empty after reset: mask 0
    cycle(0, 0, 0, 0);
    do_reset(1);
    force_tag = "R12";
    cycle(1, 0, 0, 'h21);   // R12 absence mode active: mask 1110
    cycle(1, 3, 2, 'h21);   // R11 allocate absence entry, mask 1011
    cycle(1, 3, 1, 'h21);   // R10 hit, kept
    cycle(1, 2, 1, 'h21);   // R6 nothing
    cycle(1, 0, 3, 'h21);   // R10 hit mask 0, freed
    cycle(1, 1, 3, 'h21);   // R11 miss
    cycle(1, 3, 0, 'h04);
    cycle(1, 3, 0, 'h08);
    cycle(1, 3, 0, 'h0C);   // R11 replacement without binv
    cycle(0, 0, 0, 0);
    rand_run(4000);
    cycle(0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule